// File: doc/BRIEF.md
# GPIO Interrupt and Wake Aggregator

This block collects interrupt and wake events from a bank of GPIO pins and presents them to the host as one interrupt line. Every pin has its own 32-bit register. Each register holds:

- the detection mode (level or edge) and the active polarity;
- an interrupt enable and a delivery mask;
- three wake enables, one for each sleep state;
- two sticky status bits, interrupt and wake, that software clears by writing 1.

A pin counts as pending when either of its status bits is set. A pending pin whose mask is 1 is delivered. The delivered pins are reduced four at a time into a 46-bit summary vector, which software reads as two status words. The host line latches high when any delivered pin is pending. It stays high until software writes the end-of-interrupt bit in the master register.

The master register also sets up a status-blocking window. When blocking is enabled, any pin write that changes that pin's debounce field starts a countdown of a programmed number of cycles. During the countdown no pin can set either status bit, and every interrupt-enable bit reads back as 0. Software polls an enable bit until it reads 1 again to learn when the window has closed.

The register port is a plain single-cycle write strobe with a combinational read. The pin and sleep-state inputs are plain levels, so the block has no valid/ready interface and no back-pressure rules.

Top module: `gpio_irq_aggr`

## Requirements
- R1: After reset, every pin register, both status words, the master register and `host_irq` read 0.
- R2: Pin register layout. Bit 0 selects level mode (1) or edge mode (0). Bits 2:1 hold the active code. Bit 3 is the interrupt enable and bit 4 the delivery mask. Bits 5, 6 and 7 are the wake enables for sleep codes 1, 2 and 3. Bit 8 is the interrupt status and bit 9 the wake status, both write-1-to-clear. Bit 10 is the synchronized pin level and is read-only. Bits 15:12 are a debounce field that software can read and write. All other bits read 0.
- R3: In level mode, active code 01 means active-low and any other code means active-high. The interrupt status sets while the enabled pin is at its active level, and it sets again right after a clear if the level is still active.
- R4: In edge mode, active code 00 detects rising edges, 01 falling edges and 1x both edges. The status latches once per qualifying edge. After a write-1 clear it stays 0 while the input holds steady.
- R5: While its interrupt enable is 0, a pin never sets its interrupt status.
- R6: A pin with mask 0 still records its status, but it contributes nothing to the summary vector or to `host_irq`.
- R7: `sleep_state` encodes 0 = awake, 1 = light idle, 2 = standby, 3 = off. A detected event sets the wake status when the wake enable for the current nonzero code is 1, whether or not the interrupt enable is set. In the awake state no wake status is set.
- R8: Summary bit n is 1 when any of pins 4n to 4n+3 is pending and delivered. Bits 31:0 of the summary read at address 2^ADDR_W-3. Bits 45:32 read in bits 13:0 at address 2^ADDR_W-2, and the upper bits of that word read 0. Pin k sits at address k.
- R9: `host_irq` rises one cycle after a delivered pending pin appears. It then stays high even after the status is cleared, until a write with bit 0 set to the master register (address 2^ADDR_W-1). That write drops `host_irq` for one cycle, and `host_irq` rises again on the next cycle if any delivered pin is still pending.
- R10: Master bit 1 enables blocking and bits 27:16 hold the window length L. With blocking enabled, a pin write that changes that pin's debounce field suppresses status setting on all pins for the next L cycles. During that time every interrupt-enable bit reads 0.
- R11: The master register reads back its bit 1 and bits 27:16, and bit 0 always reads 0. With blocking disabled, a debounce change does not hide the enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_PINS | Raw pin levels |
| sleep_state | input | 2 | Current sleep state code |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| host_irq | output | 1 | Latched host interrupt |

## Verification
The bench builds the block with NUM_PINS = 138 and ADDR_W = 8. With 35 groups, the summary spills into the upper status word. The last group is also only half populated (pins 136 and 137), so both the word split of the summary and a partial group get exercised. A table of mode, polarity and input-transition vectors is run on one pin. Directed tests then cover:

- the end-of-interrupt re-arm;
- wake gating by sleep state;
- the exact blocking window.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int F_LEVEL  = 0;
  localparam int F_ACT    = 1;
  localparam int F_IEN    = 3;
  localparam int F_MASK   = 4;
  localparam int F_WAKE   = 5;
  localparam int F_ISTS   = 8;
  localparam int F_WSTS   = 9;
  localparam int F_PIN    = 10;
  localparam int F_DB     = 12;
  localparam int DB_W     = 4;
  localparam int M_EOI    = 0;
  localparam int M_BLK_EN = 1;
  localparam int M_LEN    = 16;
  localparam int LEN_W    = 12;
  localparam int SUM_W    = 46;

  typedef enum logic [1:0] {
    ACT_HIGH = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_BOTH = 2'b10
  } act_e;

  typedef enum logic [1:0] {
    SLP_AWAKE = 2'd0,
    SLP_IDLE  = 2'd1,
    SLP_STBY  = 2'd2,
    SLP_OFF   = 2'd3
  } sleep_e;
endpackage

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        blocking_i,
  input  logic [1:0]  sleep_i,
  output logic [31:0] rdata_o,
  output logic        pend_o,
  output logic        db_chg_o
);
  logic            s1_q, s2_q;
  logic            lvl_q, ien_q, msk_q;
  logic [1:0]      act_q;
  logic [2:0]      wk_q;
  logic [DB_W-1:0] db_q;
  logic            ista_q, wsta_q;
  logic            rise, fall, lvl_on, hit, wake_sel;
  logic            set_i, set_w, clr_i, clr_w;
  logic            unused_wbits;

  assign unused_wbits = ^{wdata_i[31:16], wdata_i[11:10]};

  always_comb begin
    rise   = s1_q & ~s2_q;
    fall   = ~s1_q & s2_q;
    lvl_on = (act_q == ACT_LOW) ? ~s1_q : s1_q;
    if (lvl_q)          hit = lvl_on;
    else if (act_q[1])  hit = rise | fall;
    else if (act_q[0])  hit = fall;
    else                hit = rise;
    case (sleep_i)
      SLP_IDLE: wake_sel = wk_q[0];
      SLP_STBY: wake_sel = wk_q[1];
      SLP_OFF:  wake_sel = wk_q[2];
      default:  wake_sel = 1'b0;
    endcase
    set_i = hit & ien_q & ~blocking_i;
    set_w = hit & wake_sel & ~blocking_i;
    clr_i = wr_i & wdata_i[F_ISTS];
    clr_w = wr_i & wdata_i[F_WSTS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0; s2_q <= 1'b0;
      lvl_q <= 1'b0; act_q <= 2'b00; ien_q <= 1'b0; msk_q <= 1'b0;
      wk_q <= '0; db_q <= '0;
      ista_q <= 1'b0; wsta_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (wr_i) begin
        lvl_q <= wdata_i[F_LEVEL];
        act_q <= wdata_i[F_ACT +: 2];
        ien_q <= wdata_i[F_IEN];
        msk_q <= wdata_i[F_MASK];
        wk_q  <= wdata_i[F_WAKE +: 3];
        db_q  <= wdata_i[F_DB +: DB_W];
      end
      ista_q <= set_i | (ista_q & ~clr_i);
      wsta_q <= set_w | (wsta_q & ~clr_w);
    end
  end

  assign db_chg_o = wr_i && (wdata_i[F_DB +: DB_W] != db_q);
  assign pend_o   = (ista_q | wsta_q) & msk_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[F_LEVEL]       = lvl_q;
    rdata_o[F_ACT +: 2]    = act_q;
    rdata_o[F_IEN]         = ien_q & ~blocking_i;
    rdata_o[F_MASK]        = msk_q;
    rdata_o[F_WAKE +: 3]   = wk_q;
    rdata_o[F_ISTS]        = ista_q;
    rdata_o[F_WSTS]        = wsta_q;
    rdata_o[F_PIN]         = s1_q;
    rdata_o[F_DB +: DB_W]  = db_q;
  end

  // R5: a disabled pin never raises its interrupt status
  p_gate_ien_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ien_q && !ista_q |=> !ista_q);
  // R10: no status appears while the window is open
  p_block_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blocking_i && !ista_q && !wsta_q |=> !ista_q && !wsta_q);
  // R7: nothing wakes while awake
  p_wake_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i == SLP_AWAKE && !wsta_q |=> !wsta_q);
endmodule

// File: rtl/gpio_group_or.sv
module gpio_group_or #(
  parameter int NUM_PINS = 184,
  parameter int OUT_W    = 46
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [OUT_W-1:0]    sum_o
);
  localparam int GROUPS = (NUM_PINS + 3) / 4;
  localparam int PAD_W  = GROUPS * 4;

  logic [PAD_W-1:0] pad;
  assign pad = PAD_W'(pend_i);

  for (genvar g = 0; g < OUT_W; g++) begin : g_grp
    if (g < GROUPS) begin : g_live
      assign sum_o[g] = |pad[4*g +: 4];
    end else begin : g_none
      assign sum_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_block_timer.sv
module gpio_block_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             blocking_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (trig_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign blocking_o = (cnt_q != '0);

  // R10: the window shrinks by one each cycle unless re-triggered
  p_count_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0 && !trig_i |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/gpio_irq_aggr.sv
module gpio_irq_aggr
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] gpio_in,
  input  logic [1:0]          sleep_state,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                host_irq
);
  localparam logic [ADDR_W-1:0] A_MASTER = ADDR_W'((1 << ADDR_W) - 1);
  localparam logic [ADDR_W-1:0] A_SUMHI  = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] A_SUMLO  = ADDR_W'((1 << ADDR_W) - 3);

  logic [31:0]         pin_rd [NUM_PINS];
  logic [NUM_PINS-1:0] pend, db_chg;
  logic [SUM_W-1:0]    summary;
  logic                blocking, trig, wr_master, eoi;
  logic                blk_en_q;
  logic [LEN_W-1:0]    blk_len_q;
  logic                irq_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_slice u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (gpio_in[i]),
      .wr_i       (reg_we && (reg_addr == ADDR_W'(i))),
      .wdata_i    (reg_wdata),
      .blocking_i (blocking),
      .sleep_i    (sleep_state),
      .rdata_o    (pin_rd[i]),
      .pend_o     (pend[i]),
      .db_chg_o   (db_chg[i])
    );
  end

  gpio_group_or #(.NUM_PINS(NUM_PINS), .OUT_W(SUM_W)) u_or (
    .pend_i (pend),
    .sum_o  (summary)
  );

  assign wr_master = reg_we && (reg_addr == A_MASTER);
  assign eoi       = wr_master && reg_wdata[M_EOI];
  assign trig      = blk_en_q && (|db_chg);

  gpio_block_timer #(.CNT_W(LEN_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_i     (trig),
    .len_i      (blk_len_q),
    .blocking_o (blocking)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_en_q  <= 1'b0;
      blk_len_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_master) begin
        blk_en_q  <= reg_wdata[M_BLK_EN];
        blk_len_q <= reg_wdata[M_LEN +: LEN_W];
      end
      if (eoi)               irq_q <= 1'b0;
      else if (|summary)     irq_q <= 1'b1;
    end
  end

  assign host_irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_MASTER) begin
      reg_rdata[M_BLK_EN]       = blk_en_q;
      reg_rdata[M_LEN +: LEN_W] = blk_len_q;
    end else if (reg_addr == A_SUMHI) begin
      reg_rdata[SUM_W-33:0] = summary[SUM_W-1:32];
    end else if (reg_addr == A_SUMLO) begin
      reg_rdata = summary[31:0];
    end else begin
      for (int i = 0; i < NUM_PINS; i++)
        if (reg_addr == ADDR_W'(i)) reg_rdata = pin_rd[i];
    end
  end

  // R9: end-of-interrupt drops the line on the next cycle
  p_eoi_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !host_irq);
  // R9: the line only rises from a delivered pending pin
  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(|summary));
  // R9: once high the line holds until end-of-interrupt
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq && !eoi |=> host_irq);
endmodule

// File: tb/gpio_irq_aggr_bench.sv
module gpio_irq_aggr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 138;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_MASTER = 8'd255;
  localparam logic [AW-1:0] A_SUMHI  = 8'd254;
  localparam logic [AW-1:0] A_SUMLO  = 8'd253;
  localparam int TP = 5;  // table pin, group 1

  // {level, act[1:0], v0, v1, expected status}
  localparam logic [5:0] VEC [13] = '{
    6'b0_00_01_1, 6'b0_00_10_0, 6'b0_00_11_0,
    6'b0_01_10_1, 6'b0_01_01_0,
    6'b0_10_01_1, 6'b0_10_10_1, 6'b0_10_00_0,
    6'b1_00_01_1, 6'b1_00_00_0,
    6'b1_01_10_1, 6'b1_01_11_0,
    6'b1_10_01_1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] gpio_in = '0;
  logic [1:0]    sleep_state = 2'd0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          host_irq;
  int            n_chk = 0;
  int            n_fail = 0;
  logic [31:0]   r;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_aggr #(.NUM_PINS(NP), .ADDR_W(AW)) u_gpio_irq_aggr (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .sleep_state(sleep_state),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    step(200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'd0, r);      chk("R1 pin0", r, 0);
    rd(8'd137, r);    chk("R1 pin137", r, 0);
    rd(A_SUMLO, r);   chk("R1 sumlo", r, 0);
    rd(A_SUMHI, r);   chk("R1 sumhi", r, 0);
    rd(A_MASTER, r);  chk("R1 master", r, 0);
    chk("R1 host_irq", 32'(host_irq), 0);

    // R2 field layout and read-only pin level
    wr(8'd3, 32'hFFFF_F0F7);
    rd(8'd3, r);      chk("R2 readback", r, 32'h0000_F0F7);
    gpio_in[3] = 1'b1; step(3);
    rd(8'd3, r);      chk("R2 pin level", r, 32'h0000_F4F7);
    wr(8'd3, 32'h0);

    // R5 disabled pin does not latch
    wr(8'd7, 32'h10);
    gpio_in[7] = 1'b1; step(4);
    rd(8'd7, r);      chk("R5 no status", 32'(r[8]), 0);

    // R6 masked pin latches but is not delivered
    wr(8'd9, 32'h08);
    gpio_in[9] = 1'b1; step(4);
    rd(8'd9, r);      chk("R6 status", 32'(r[8]), 1);
    rd(A_SUMLO, r);   chk("R6 summary", r, 0);
    chk("R6 host_irq", 32'(host_irq), 0);
    wr(8'd9, 32'h0); wr(8'd9, 32'h300);

    // R3/R4 vector table on one pin
    foreach (VEC[k]) begin
      logic [31:0] cfg;
      cfg = 32'(VEC[k][5]) | (32'(VEC[k][4:3]) << 1) | 32'h10;
      wr(8'(TP), cfg);
      gpio_in[TP] = VEC[k][2]; step(3);
      wr(8'(TP), cfg | 32'h308);
      step(2);
      gpio_in[TP] = VEC[k][1]; step(4);
      rd(8'(TP), r);
      chk(VEC[k][5] ? "R3 table status" : "R4 table status", 32'(r[8]), 32'(VEC[k][0]));
      rd(A_SUMLO, r);
      chk("R8 table summary", 32'(r[1]), 32'(VEC[k][0]));
    end

    // R9 latched line survives status clear, EOI drops it
    wr(8'(TP), 32'h0); wr(8'(TP), 32'h300);
    rd(A_SUMLO, r);   chk("R9 cleared summary", r, 0);
    chk("R9 latched", 32'(host_irq), 1);
    wr(A_MASTER, 32'h1);
    chk("R9 eoi drop", 32'(host_irq), 0);
    step(3);
    chk("R9 stays low", 32'(host_irq), 0);

    // R8 summary split and partial group
    wr(8'd133, 32'h318); gpio_in[133] = 1'b1; step(4);
    rd(A_SUMHI, r);   chk("R8 upper word", r, 32'h2);
    rd(A_SUMLO, r);   chk("R8 lower word", r, 0);
    wr(8'd8, 32'h318); wr(8'd11, 32'h318);
    gpio_in[8] = 1'b1; gpio_in[11] = 1'b1; step(4);
    rd(A_SUMLO, r);   chk("R8 shared group", r, 32'h4);
    wr(8'd137, 32'h318); gpio_in[137] = 1'b1; step(4);
    rd(A_SUMHI, r);   chk("R8 partial group", r, 32'h6);
    chk("R9 asserted", 32'(host_irq), 1);
    wr(A_MASTER, 32'h1);
    chk("R9 eoi gap", 32'(host_irq), 0);
    step(1);
    chk("R9 rearm", 32'(host_irq), 1);

    // R7 wake by sleep state
    sleep_state = 2'd2;
    wr(8'd20, 32'h50); gpio_in[20] = 1'b1; step(4);
    rd(8'd20, r);
    chk("R7 wake status", 32'(r[9]), 1);
    chk("R7 irq status", 32'(r[8]), 0);
    rd(A_SUMLO, r);   chk("R7 wake summary", 32'(r[5]), 1);
    sleep_state = 2'd1;
    wr(8'd24, 32'h50); gpio_in[24] = 1'b1; step(4);
    rd(8'd24, r);     chk("R7 wrong state", 32'(r[9]), 0);
    sleep_state = 2'd0;

    // R3 level status re-sets after clear
    wr(8'd30, 32'h19); gpio_in[30] = 1'b1; step(4);
    rd(8'd30, r);     chk("R3 level set", 32'(r[8]), 1);
    wr(8'd30, 32'h119); step(2);
    rd(8'd30, r);     chk("R3 level re-set", 32'(r[8]), 1);
    gpio_in[30] = 1'b0; step(3);
    wr(8'd30, 32'h119); step(2);
    rd(8'd30, r);     chk("R3 level released", 32'(r[8]), 0);

    // R4 edge status stays clear while input holds
    wr(8'd31, 32'h18); gpio_in[31] = 1'b1; step(4);
    rd(8'd31, r);     chk("R4 edge set", 32'(r[8]), 1);
    wr(8'd31, 32'h118); step(4);
    rd(8'd31, r);     chk("R4 edge cleared", 32'(r[8]), 0);

    // R10/R11 blocking window
    wr(8'd40, 32'h19);
    wr(A_MASTER, 32'h0006_0002);
    rd(A_MASTER, r);  chk("R11 master readback", r, 32'h0006_0002);
    wr(8'd40, 32'h1019);
    gpio_in[40] = 1'b1; step(2);
    rd(8'd40, r);
    chk("R10 enable hidden", 32'(r[3]), 0);
    chk("R10 status blocked", 32'(r[8]), 0);
    step(8);
    rd(8'd40, r);
    chk("R10 enable back", 32'(r[3]), 1);
    chk("R10 status after window", 32'(r[8]), 1);
    wr(A_MASTER, 32'h0);
    rd(A_MASTER, r);  chk("R11 master cleared", r, 0);
    wr(8'd40, 32'h2019);
    rd(8'd40, r);     chk("R11 no block", 32'(r[3]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule